// File: doc/BRIEF.md
# Two-Level Page Table Walker

When a translation buffer misses, this block turns a 32-bit virtual address into a leaf page table entry. It walks a page table with two levels that is held in main memory. A request brings the virtual address and the base address of the directory. The walker then makes two word reads in a row on a simple memory read port. The first read fetches a directory entry, and that entry names a second-level table. The second read fetches the leaf entry from that table.

If either entry is marked invalid, the walk ends with a page-fault response and no fill is produced. A successful walk returns the leaf entry, with its reference bit set, ready to be loaded into the buffer. It also returns the full physical address. Only one walk is in progress at a time.

The virtual address splits as 10/10/12:
- bits 31..22 index the directory;
- bits 21..12 index the second-level table;
- bits 11..0 are the page offset, which passes through untranslated.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `mem_req` and `resp_valid` are all low.
- R2: A cycle with `miss_valid` high and `busy` low starts a walk. From the next cycle, `mem_req` is high with `mem_addr` equal to `miss_base` plus 4 times the captured vaddr bits 31..22.
- R3: `miss_valid` has no effect while `busy` is high. The walk in progress keeps its own addresses and result.
- R4: Once raised, `mem_req` stays high and `mem_addr` stays unchanged until a cycle in which `mem_rvalid` is high. That cycle completes the read, and `mem_rdata` carries the word.
- R5: Entry format for both levels: bit 0 valid, bit 1 read permission, bit 2 write permission, bit 3 referenced, bit 4 dirty, bits 31..12 page frame. A valid directory entry causes a second read at ({entry[31:12], 12'h000}) plus 4 times vaddr bits 21..12. The entry's low 12 bits do not affect that address.
- R6: If the directory entry has bit 0 clear, the walk issues no second read. It responds with `resp_fault`=1, `resp_fault_lvl`=0, `resp_pte`=0 and `resp_paddr`=0.
- R7: If the leaf entry has bit 0 clear, the walk responds with `resp_fault`=1, `resp_fault_lvl`=1, `resp_pte`=0 and `resp_paddr`=0.
- R8: If the leaf entry is valid, the walk responds with `resp_fault`=0 and `resp_pte` equal to the leaf entry with bit 3 forced to 1. `resp_paddr` equals {leaf[31:12], vaddr[11:0]}.
- R9: `resp_valid` is high for exactly one cycle, the cycle after the last read completes. `busy` stays high through that cycle and is low in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_vaddr | input | 32 | Virtual address to translate |
| miss_base | input | 32 | Directory base address |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read request, held until served |
| mem_addr | output | 32 | Memory word read address |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| resp_valid | output | 1 | Walk result strobe |
| resp_fault | output | 1 | Page fault result |
| resp_fault_lvl | output | 1 | Fault level: 0 directory, 1 leaf |
| resp_pte | output | 32 | Leaf entry for the buffer fill |
| resp_paddr | output | 32 | Translated physical address |

## Verification
A wrong walk state shows up quickly at the ports, within one cycle:
- a corrupt captured address or table base puts a wrong `mem_addr` in the first cycle of the affected read;
- a wrong state puts `mem_req` or `busy` out of step with the reference model in the very next cycle.

Errors in the fault or fill path appear in the single response cycle. Each such error changes `resp_fault`, `resp_fault_lvl`, `resp_pte` or `resp_paddr`. The model is compared every clock, so the first wrong cycle is the one reported.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int VA_W    = 32,
  parameter int PG_W    = 12,
  parameter int L2_W    = 10,
  parameter int REF_BIT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            miss_valid,
  input  logic [VA_W-1:0] miss_vaddr,
  input  logic [VA_W-1:0] miss_base,
  output logic            busy,
  output logic            mem_req,
  output logic [VA_W-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [VA_W-1:0] mem_rdata,
  output logic            resp_valid,
  output logic            resp_fault,
  output logic            resp_fault_lvl,
  output logic [VA_W-1:0] resp_pte,
  output logic [VA_W-1:0] resp_paddr
);
  localparam int L1_W = VA_W - PG_W - L2_W;
  localparam int Z1_W = VA_W - L1_W - 2;
  localparam int Z2_W = VA_W - L2_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_LEAF, S_RESP} st_t;
  st_t st;

  logic [VA_W-1:0] va_q, base_q, tbl_q;

  wire [VA_W-1:0] dir_addr  = base_q + {{Z1_W{1'b0}}, va_q[VA_W-1 -: L1_W], 2'b00};
  wire [VA_W-1:0] leaf_addr = tbl_q  + {{Z2_W{1'b0}}, va_q[PG_W +: L2_W], 2'b00};

  assign busy       = (st != S_IDLE);
  assign mem_req    = (st == S_DIR) || (st == S_LEAF);
  assign mem_addr   = (st == S_LEAF) ? leaf_addr : dir_addr;
  assign resp_valid = (st == S_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      va_q           <= '0;
      base_q         <= '0;
      tbl_q          <= '0;
      resp_fault     <= 1'b0;
      resp_fault_lvl <= 1'b0;
      resp_pte       <= '0;
      resp_paddr     <= '0;
    end else begin
      case (st)
        S_IDLE: if (miss_valid) begin
          va_q   <= miss_vaddr;
          base_q <= miss_base;
          st     <= S_DIR;
        end
        S_DIR: if (mem_rvalid) begin
          if (mem_rdata[0]) begin
            tbl_q <= {mem_rdata[VA_W-1:PG_W], {PG_W{1'b0}}};
            st    <= S_LEAF;
          end else begin
            resp_fault     <= 1'b1;
            resp_fault_lvl <= 1'b0;
            resp_pte       <= '0;
            resp_paddr     <= '0;
            st             <= S_RESP;
          end
        end
        S_LEAF: if (mem_rvalid) begin
          resp_fault_lvl <= 1'b1;
          if (mem_rdata[0]) begin
            resp_fault          <= 1'b0;
            resp_pte            <= mem_rdata;
            resp_pte[REF_BIT]   <= 1'b1;
            resp_paddr          <= {mem_rdata[VA_W-1:PG_W], va_q[PG_W-1:0]};
          end else begin
            resp_fault <= 1'b1;
            resp_pte   <= '0;
            resp_paddr <= '0;
          end
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !busy) |=> mem_req &&
      mem_addr == $past(miss_base) + {{Z1_W{1'b0}}, $past(miss_vaddr[VA_W-1 -: L1_W]), 2'b00});

  assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> mem_req && $stable(mem_addr));

  assert_dir_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIR && mem_rvalid && !mem_rdata[0]) |=> resp_valid && resp_fault && !resp_fault_lvl);

  assert_fault_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> resp_pte == '0 && resp_paddr == '0);

  assert_fill_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> resp_pte[REF_BIT] && resp_pte[0]);

  assert_one_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && !busy);
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0, miss_base = '0;
  logic busy, mem_req, resp_valid, resp_fault, resp_fault_lvl;
  logic [31:0] mem_addr, resp_pte, resp_paddr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_base(miss_base), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_fault_lvl(resp_fault_lvl), .resp_pte(resp_pte),
    .resp_paddr(resp_paddr));

  int tests = 0, fails = 0, cycles = 0;
  logic [31:0] ram [int unsigned];
  int lat_cfg = 0, wcnt = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return ram.exists(a) ? ram[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 idle, 1 directory read, 2 leaf read, 3 answer
  int ph = 0;
  logic [31:0] m_va, m_base, m_tb, e_pte, e_pa;
  logic e_fault, e_lvl;

  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (miss_valid) begin m_va = miss_vaddr; m_base = miss_base; ph = 1; end
      1: if (mem_rvalid) begin
           if (mem_rdata[0]) begin m_tb = mem_rdata & 32'hFFFF_F000; ph = 2; end
           else begin e_fault = 1; e_lvl = 0; e_pte = 0; e_pa = 0; ph = 3; end
         end
      2: if (mem_rvalid) begin
           e_lvl = 1;
           if (mem_rdata[0]) begin
             e_fault = 0; e_pte = mem_rdata | 32'h8;
             e_pa = (mem_rdata & 32'hFFFF_F000) | (m_va & 32'hFFF);
           end else begin e_fault = 1; e_pte = 0; e_pa = 0; end
           ph = 3;
         end
      default: ph = 0;
    endcase
  end

  always @(negedge clk) begin
    logic [31:0] ea;
    cycles++;
    if (rst_n) begin
      chk(busy === (ph != 0), "R9 busy", {31'b0, busy}, {31'b0, ph != 0});
      chk(mem_req === (ph == 1 || ph == 2), "R4 mem_req", {31'b0, mem_req}, {31'b0, ph == 1 || ph == 2});
      if (ph == 1) begin
        ea = m_base + {20'b0, m_va[31:22], 2'b00};
        chk(mem_addr === ea, "R2 dir addr", mem_addr, ea);
      end
      if (ph == 2) begin
        ea = m_tb + {20'b0, m_va[21:12], 2'b00};
        chk(mem_addr === ea, "R5 leaf addr", mem_addr, ea);
      end
      chk(resp_valid === (ph == 3), "R9 resp_valid", {31'b0, resp_valid}, {31'b0, ph == 3});
      if (ph == 3 && resp_valid) begin
        chk(resp_fault === e_fault, e_fault ? (e_lvl ? "R7 fault" : "R6 fault") : "R8 fault",
            {31'b0, resp_fault}, {31'b0, e_fault});
        if (e_fault)
          chk(resp_fault_lvl === e_lvl, e_lvl ? "R7 level" : "R6 level",
              {31'b0, resp_fault_lvl}, {31'b0, e_lvl});
        chk(resp_pte === e_pte, e_fault ? "R7 pte" : "R8 pte", resp_pte, e_pte);
        chk(resp_paddr === e_pa, e_fault ? "R7 paddr" : "R8 paddr", resp_paddr, e_pa);
      end
    end
    if (mem_rvalid) begin mem_rvalid = 1'b0; wcnt = 0; end
    else if (mem_req) begin
      if (wcnt >= lat_cfg) begin mem_rvalid = 1'b1; mem_rdata = rd(mem_addr); end
      else wcnt++;
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input int lat, input bit noise);
    lat_cfg = lat;
    while (busy) @(negedge clk);
    miss_vaddr = va; miss_base = base; miss_valid = 1'b1;
    @(negedge clk);
    if (noise) begin
      // R3: a second request while busy must be ignored
      miss_vaddr = 32'h0180_2555; miss_base = 32'h0700_0000;
      @(negedge clk); @(negedge clk);
    end
    miss_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    ram[32'h0040_0014] = 32'h0080_0A01;
    ram[32'h0080_000C] = 32'h1234_5007;
    ram[32'h0080_0010] = 32'h5555_5006;
    ram[32'h0040_0FFC] = 32'h0090_0001;
    ram[32'h0090_0FFC] = 32'hFFFF_F01B;
    ram[32'h0100_0000] = 32'h00A0_0001;
    ram[32'h00A0_0000] = 32'h0000_1003;
    ram[32'h0700_0018] = 32'h00B0_0001;
    ram[32'h00B0_0008] = 32'h7777_7003;

    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && mem_req === 1'b0 && resp_valid === 1'b0, "R1 reset",
        {29'b0, busy, mem_req, resp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    walk(32'h0140_3ABC, 32'h0040_0000, 0, 0);   // R8 fill, R5 masked table base
    chk(resp_pte === 32'h1234_500F, "R8 direct pte", resp_pte, 32'h1234_500F);
    walk(32'h0180_3ABC, 32'h0040_0000, 1, 0);   // R6 directory invalid
    walk(32'h0140_4000, 32'h0040_0000, 2, 0);   // R7 leaf invalid
    walk(32'hFFFF_F123, 32'h0040_0000, 3, 0);   // top indices, ref already set
    chk(resp_paddr === 32'hFFFF_F123, "R8 direct paddr", resp_paddr, 32'hFFFF_F123);
    walk(32'h0000_0FFF, 32'h0100_0000, 2, 1);   // R3 request during walk ignored
    chk(resp_paddr === 32'h0000_1FFF, "R3 first walk kept", resp_paddr, 32'h0000_1FFF);
    walk(32'h0180_2555, 32'h0700_0000, 0, 0);   // the ignored request, now accepted
    chk(resp_paddr === 32'h7777_7555, "R2 later accept", resp_paddr, 32'h7777_7555);

    // back-to-back: request held high across the answer
    lat_cfg = 1;
    miss_vaddr = 32'h0140_3001; miss_base = 32'h0040_0000; miss_valid = 1'b1;
    while (!resp_valid) @(negedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R9 idle gap", {31'b0, busy}, 32'h0);
    @(negedge clk);
    miss_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++; tests++;
    $display("FAIL watchdog act=%0d exp<20000", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule